// File: doc/BRIEF.md
# Two-Byte Conversion Result Bus Reader

This block puts a 10-bit conversion result onto an 8-bit processor-style data bus as two reads in a row. The result is left-justified in a 16-bit word. The first read returns the upper eight result bits. The second read returns the two lowest result bits in the top two lanes, with zeros in the remaining six lanes. A byte pointer tracks which half comes next. It returns to the upper half whenever a fresh result is loaded. A new result that arrives during a read is held back until that read strobe ends, so a single read never returns a mix of two results.

The block also owns the interrupt handshake. An end-of-conversion set pulse from the sequencer raises the active-low interrupt. A read by the host clears it. The set pulse takes priority over the clear. As a result, a host that holds the bus permanently in read still sees one interrupt pulse per conversion, and that pulse is exactly as long as the set pulse. All bus timing is counted in clock cycles. The three-state driver is represented by an output-enable signal.

Top module: `adc_byte_rd_if`

## Requirements
- R1: After a result is loaded, the next read returns the high byte.
- R2: The high byte carries result bits 9..2 on data lanes 7..0.
- R3: The low byte carries result bits 1..0 on data lanes 7..6. Lanes 5..0 read as 0.
- R4: `data_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both 0. It is 0 otherwise, including while either one alone is low.
- R5: The pointer advances at the end of a read strobe, in this order: high byte, low byte, then high byte again. It stays on the high byte for every later read until a new result is loaded.
- R6: A read, meaning `cs_ni` and `rd_ni` both low and sampled at a clock edge with `eoc_set_i` low, clears the interrupt: `intr_no` is 1 after that edge.
- R7: While `rst_ni` is 0, `data_oe_o` is 0 and `intr_no` is 1. After reset the pointer is on the high byte, and the held result is 0.
- R8: If a result is loaded while a read is active, the bus keeps the old data for the rest of that strobe. The new result, starting with its high byte, is used from the next read onward.
- R9: While `eoc_set_i` is 1, the interrupt stays set even with a read held active. With the read held continuously, `intr_no` is 0 for exactly as many cycles as `eoc_set_i` was 1.
- R10: `intr_no` goes to 0 at the first clock edge at which `eoc_set_i` is sampled high. The result is captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| result_i | input | 10 | Result from the conversion sequencer |
| eoc_set_i | input | 1 | End-of-conversion set pulse; its first cycle loads `result_i` |
| data_o | output | 8 | Byte presented to the bus |
| data_oe_o | output | 1 | Bus driver enable |
| intr_no | output | 1 | Interrupt, active low |

## Verification
A stuck or mis-stepped byte pointer shows up on the very next read. The bus returns the wrong half of the result, for example a low byte where a high byte belongs, or fails to park on the high byte after the second read. A lost or early-applied deferred load shows up in one of two ways: the data changes in the middle of a strobe, or the read after the strobe returns the low byte of the old result. A wrong set-over-clear priority in the interrupt flag changes the length of the interrupt pulse under a held read within the set-pulse window. It also leaves the interrupt low after a read, which is visible one cycle later.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W = 10;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    PTR_HI_FIRST = 2'd0,
    PTR_LO       = 2'd1,
    PTR_HI_PARK  = 2'd2
  } byte_ptr_e;
endpackage

// File: rtl/rd_strobe_det.sv
module rd_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  output logic rd_act_o,
  output logic rd_end_o
);
  logic rd_act_q;

  assign rd_act_o = ~cs_ni & ~rd_ni & rst_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_act_q <= 1'b0;
    else         rd_act_q <= rd_act_o;
  end

  assign rd_end_o = rd_act_q & ~rd_act_o;
endmodule

// File: rtl/result_holder.sv
module result_holder
  import adc_rd_pkg::*;
#(
  parameter int RES_W = adc_rd_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoc_set_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             rd_act_i,
  input  logic             rd_end_i,
  output logic [RES_W-1:0] res_o,
  output byte_ptr_e        ptr_o
);
  logic             eoc_q;
  logic             load_evt;
  logic             pend_q;
  logic [RES_W-1:0] pend_res_q;
  logic [RES_W-1:0] res_q;
  byte_ptr_e        ptr_q;
  byte_ptr_e        ptr_next;

  assign load_evt = eoc_set_i & ~eoc_q;

  always_comb begin
    unique case (ptr_q)
      PTR_HI_FIRST: ptr_next = PTR_LO;
      PTR_LO:       ptr_next = PTR_HI_PARK;
      default:      ptr_next = PTR_HI_PARK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_res_q <= '0;
      res_q      <= '0;
      ptr_q      <= PTR_HI_FIRST;
    end else begin
      eoc_q <= eoc_set_i;
      if (load_evt && !rd_act_i) begin
        res_q  <= result_i;
        ptr_q  <= PTR_HI_FIRST;
        pend_q <= 1'b0;
      end else if (load_evt) begin
        // read in flight: hold until strobe ends
        pend_q     <= 1'b1;
        pend_res_q <= result_i;
      end else if (pend_q && !rd_act_i) begin
        res_q  <= pend_res_q;
        ptr_q  <= PTR_HI_FIRST;
        pend_q <= 1'b0;
      end else if (rd_end_i) begin
        ptr_q <= ptr_next;
      end
    end
  end

  assign res_o = res_q;
  assign ptr_o = ptr_q;

  assert_defer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i && rd_act_i == $past(rd_act_i) && pend_q) |=> $stable(res_q) || !$past(rd_act_i))
    else $error("R8 result changed during read");

  assert_park_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_HI_PARK && !eoc_set_i && !pend_q) |=> ptr_q == PTR_HI_PARK)
    else $error("R5 pointer left park without load");
endmodule

// File: rtl/byte_fmt.sv
module byte_fmt
  import adc_rd_pkg::*;
#(
  parameter int RES_W = adc_rd_pkg::RES_W,
  parameter int BUS_W = adc_rd_pkg::BUS_W
) (
  input  logic [RES_W-1:0] res_i,
  input  byte_ptr_e        ptr_i,
  output logic [BUS_W-1:0] data_o
);
  localparam int WORD_W = 2 * BUS_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word;

  for (genvar b = 0; b < WORD_W; b++) begin : g_word
    if (b >= PAD_W) begin : g_res
      assign word[b] = res_i[b-PAD_W];
    end else begin : g_pad
      assign word[b] = 1'b0;
    end
  end

  assign data_o = (ptr_i == PTR_LO) ? word[BUS_W-1:0] : word[WORD_W-1:BUS_W];
endmodule

// File: rtl/intr_flag.sv
module intr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoc_set_i,
  input  logic rd_act_i,
  output logic intr_no
);
  logic intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intr_q <= 1'b0;
    else if (eoc_set_i) intr_q <= 1'b1;  // set dominates held read
    else if (rd_act_i)  intr_q <= 1'b0;
  end

  assign intr_no = ~intr_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_set_i |=> !intr_no)
    else $error("R9 set did not win");

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i && !eoc_set_i) |=> intr_no)
    else $error("R6 read did not clear");
endmodule

// File: rtl/adc_byte_rd_if.sv
module adc_byte_rd_if
  import adc_rd_pkg::*;
#(
  parameter int RES_W = adc_rd_pkg::RES_W,
  parameter int BUS_W = adc_rd_pkg::BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             eoc_set_i,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             intr_no
);
  logic             rd_act;
  logic             rd_end;
  logic [RES_W-1:0] res;
  byte_ptr_e        ptr;

  rd_strobe_det u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .rd_act_o (rd_act),
    .rd_end_o (rd_end)
  );

  result_holder #(.RES_W(RES_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoc_set_i (eoc_set_i),
    .result_i  (result_i),
    .rd_act_i  (rd_act),
    .rd_end_i  (rd_end),
    .res_o     (res),
    .ptr_o     (ptr)
  );

  byte_fmt #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
    .res_i  (res),
    .ptr_i  (ptr),
    .data_o (data_o)
  );

  intr_flag u_intr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoc_set_i (eoc_set_i),
    .rd_act_i  (rd_act),
    .intr_no   (intr_no)
  );

  assign data_oe_o = rd_act;

  assert_low_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && ptr == PTR_LO) |-> data_o[5:0] == '0)
    else $error("R3 padding not zero");

  assert_load_hi_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_set_i && !$past(eoc_set_i) && !rd_act) |=> ptr == PTR_HI_FIRST)
    else $error("R1 load did not select high byte");
endmodule

// File: tb/sim_adc_byte_rd_if.sv
module sim_adc_byte_rd_if;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       rd_ni = 1'b1;
  logic [9:0] result = '0;
  logic       eoc = 1'b0;
  logic [7:0] data;
  logic       oe;
  logic       intr_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_byte_rd_if u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .result_i  (result),
    .eoc_set_i (eoc),
    .data_o    (data),
    .data_oe_o (oe),
    .intr_no   (intr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare first sampled byte of every strobe against the queue
  always @(negedge clk) begin
    if (oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected bus enable", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(data == e, t, data, e);
      end
    end
    oe_prev = oe;
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_neg();
    @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cs_ni = 1'b0; rd_ni = 1'b0;
    step();
    cs_ni = 1'b1; rd_ni = 1'b1;
    step();
    step();
  endtask

  task automatic convert(input logic [9:0] v, input int len);
    result = v;
    eoc = 1'b1;
    repeat (len) step();
    eoc = 1'b0;
    step();
  endtask

  function automatic logic [7:0] hi_of(input logic [9:0] v);
    return v[9:2];
  endfunction

  function automatic logic [7:0] lo_of(input logic [9:0] v);
    return {v[1:0], 6'b0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lows;
    // R7 reset state with a read request present
    cs_ni = 1'b0; rd_ni = 1'b0;
    #3;
    chk(oe == 1'b0, "R7 oe in reset", oe, 0);
    chk(intr_n == 1'b1, "R7 intr in reset", intr_n, 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    step();
    rst_ni = 1'b1;
    step();

    // R4 single strobe alone does not enable
    rd_ni = 1'b0; #1;
    chk(oe == 1'b0, "R4 rd low cs high", oe, 0);
    rd_ni = 1'b1; cs_ni = 1'b0; #1;
    chk(oe == 1'b0, "R4 cs low rd high", oe, 0);
    cs_ni = 1'b1;
    step();

    // R10 interrupt asserted at first edge of set
    result = 10'h2B5;
    eoc = 1'b1;
    wait_neg();
    chk(intr_n == 1'b1, "R10 intr before edge", intr_n, 1);
    step();
    eoc = 1'b0;
    wait_neg();
    chk(intr_n == 1'b0, "R10 intr after edge", intr_n, 0);
    step();

    // R1 R2 R3 R5 R6 byte sequence and clear
    read_byte(8'hAD, "R1 R2 first read high byte");
    chk(intr_n == 1'b1, "R6 read clears intr", intr_n, 1);
    read_byte(8'h40, "R3 R5 second read low byte");
    read_byte(8'hAD, "R5 third read parks high");
    read_byte(8'hAD, "R5 fourth read parks high");

    // more patterns
    convert(10'h3FF, 1);
    read_byte(hi_of(10'h3FF), "R2 all ones high");
    read_byte(lo_of(10'h3FF), "R3 all ones low");
    convert(10'h000, 2);
    read_byte(8'h00, "R2 zero high");
    read_byte(8'h00, "R3 zero low");
    convert(10'h003, 1);
    read_byte(8'h00, "R2 lsbs high");
    read_byte(8'hC0, "R3 lsbs low");
    convert(10'h200, 1);
    read_byte(8'h80, "R2 msb high");
    // R1 new load resets pointer mid-pair
    convert(10'h155, 1);
    read_byte(8'h55, "R1 reload restarts high");
    read_byte(8'h40, "R3 reload low");

    // R8 load during an active read
    convert(10'h2B5, 1);
    exp_q.push_back(8'hAD); tag_q.push_back("R8 strobe starts old high");
    cs_ni = 1'b0; rd_ni = 1'b0;
    step();
    result = 10'h155; eoc = 1'b1;
    step(); step();
    eoc = 1'b0;
    wait_neg();
    chk(data == 8'hAD, "R8 data held in strobe", data, 8'hAD);
    step();
    cs_ni = 1'b1; rd_ni = 1'b1;
    step(); step();
    read_byte(8'h55, "R8 next read new high");
    read_byte(8'h40, "R8 then new low");

    // R9 held read, set pulse of 3 cycles
    exp_q.push_back(8'h55); tag_q.push_back("R9 held read data");
    cs_ni = 1'b0; rd_ni = 1'b0;
    step(); step();
    chk(intr_n == 1'b1, "R9 intr clear before set", intr_n, 1);
    result = 10'h3FF; eoc = 1'b1;
    lows = 0;
    for (int i = 0; i < 3; i++) begin
      wait_neg(); if (!intr_n) lows++;
      step();
    end
    eoc = 1'b0;
    for (int i = 0; i < 5; i++) begin
      wait_neg(); if (!intr_n) lows++;
      step();
    end
    chk(lows == 3, "R9 pulse length under held read", lows, 3);
    cs_ni = 1'b1; rd_ni = 1'b1;
    step(); step();
    read_byte(8'hFF, "R9 R8 deferred high");
    read_byte(8'hC0, "R9 R8 deferred low");

    // R7 reset mid-operation
    convert(10'h2B5, 1);
    read_byte(8'hAD, "R7 pre-reset high");
    convert(10'h2B5, 1);
    cs_ni = 1'b0; rd_ni = 1'b0;
    rst_ni = 1'b0; #1;
    chk(oe == 1'b0, "R7 oe off in reset", oe, 0);
    chk(intr_n == 1'b1, "R7 intr off in reset", intr_n, 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    step();
    rst_ni = 1'b1;
    step();
    read_byte(8'h00, "R7 after reset high of zero");
    read_byte(8'h00, "R7 after reset low of zero");
    convert(10'h200, 1);
    read_byte(8'h80, "R7 after reset new high");

    step();
    chk(exp_q.size() == 0, "R4 all reads observed", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule